// File: doc/BRIEF.md
# Collective Broadcast, Scatter, Reduce and Gather Tree

This block is a binary tree of streaming nodes. It sits between one memory-side stream and N multiply leaves. Going down, each node either copies a word to both subtrees or splits a run of words between them. Going up, each node either adds the two values its subtrees return or merges their two result streams into one ordered stream. Leaves never talk to each other. Every piece of data crosses one register per tree level, so the trip from the memory side to the leaves and back grows with log2(N) and not with the number of leaves.

Each leaf is a stand-in processing element. It holds one weight (taken from a port) and a product register. For every word it receives, it returns that word multiplied by its weight. The two selects are sampled with the first word of a transfer and then travel with the data through the tree. Four useful pairings follow from this: broadcast+gather (one input times every weight), scatter+gather (element-wise products), broadcast+reduce (input times the weight sum) and scatter+reduce (dot product).

Top module: `ct_tree`

## Requirements
- R1: Every node works on a 2-bit operation code {direction, select}: 00 broadcast, 01 scatter, 10 reduce, 11 gather. At the top, `dist_sel` gives the downward select (0 broadcast, 1 scatter) and `coll_sel` gives the upward select (0 reduce, 1 gather).
- R2: In broadcast, one accepted input word reaches every leaf unchanged. With gather, the outputs are x*w[k] for k = 0..N-1.
- R3: In scatter, a transfer is N input words. Each node passes the first half of its run to its left subtree and the second half to its right subtree, so word k reaches leaf k.
- R4: In reduce, each node adds the two values from its subtrees and emits one sum. Broadcast+reduce yields x*sum(w); scatter+reduce yields sum(x[k]*w[k]).
- R5: In gather, each node emits its whole left-subtree stream before its right-subtree stream, so the outputs come out in leaf order 0..N-1.
- R6: `out_data` is 2*W+log2(N) bits wide: the product width plus one bit per level. A reduce of all-maximum operands does not overflow.
- R7: The selects are sampled with the first word of a transfer. Changes to `dist_sel` or `coll_sel` during the rest of that transfer have no effect.
- R8: All links use valid/ready. While `out_ready` is low, `out_valid` and `out_data` hold. Under any stall pattern, no result is lost and none is repeated.
- R9: A node releases a broadcast word upstream only once both of its children have taken it.
- R10: With the tree empty and `out_ready` high, the first result appears at `out_valid` exactly 2*log2(N) clock edges after the edge that accepts the input word.
- R11: After reset, `out_valid` is low and `in_ready` is high.
- R12: In broadcast+reduce with `out_ready` held high, the tree accepts one word on every cycle without dropping `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_sel | input | 1 | Downward select: 0 broadcast, 1 scatter |
| coll_sel | input | 1 | Upward select: 0 reduce, 1 gather |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Tree accepts the input word |
| in_data | input | W | Input word |
| leaf_weight | input | N*W | Weight of leaf k in bits [k*W +: W] |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Sink accepts the result |
| out_data | output | 2*W+log2(N) | Result |

## Verification
All four pairings of the selects are driven with distinct leaf weights and distinct input words.
- Broadcast+gather shows that every leaf saw the same word.
- Scatter+gather shows that word k went to leaf k and that results come back in leaf order.
- The two reduce pairings show pairwise summing.

An all-255 case exercises the widest sum. A scatter transfer whose selects flip after its first word shows that the mode is sampled once per transfer. A run with toggling `out_ready` and gaps between input words separates a correct handshake from loss or duplication. Separate scenarios measure the empty-tree latency and back-to-back acceptance.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;
   // {direction, select}: direction 0 = toward leaves, 1 = toward memory side
   typedef enum logic [1:0] {
      OP_BCAST   = 2'b00,
      OP_SCATTER = 2'b01,
      OP_REDUCE  = 2'b10,
      OP_GATHER  = 2'b11
   } coll_op_e;
endpackage

// File: rtl/ct_dist_node.sv
`timescale 1ns/1ps
module ct_dist_node
   import ct_pkg::*;
#(
   parameter int W      = 8,
   parameter int LEAVES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   input  logic         in_dist,
   input  logic         in_coll,
   output logic         lo_valid,
   input  logic         lo_ready,
   output logic [W-1:0] lo_data,
   output logic         lo_dist,
   output logic         lo_coll,
   output logic         ro_valid,
   input  logic         ro_ready,
   output logic [W-1:0] ro_data,
   output logic         ro_dist,
   output logic         ro_coll
);
   localparam int HALF = LEAVES / 2;
   localparam int CW   = $clog2(LEAVES);

   logic [CW-1:0] cnt_q;
   coll_op_e      op_q, op_now;
   logic          coll_q, coll_now;
   logic          to_right, l_free, r_free, take, load_l, load_r;

   always_comb begin
      op_now   = (cnt_q == '0) ? coll_op_e'({1'b0, in_dist}) : op_q;
      coll_now = (cnt_q == '0) ? in_coll : coll_q;
      to_right = (op_now == OP_SCATTER) && (cnt_q >= CW'(HALF));
      l_free   = !lo_valid || lo_ready;
      r_free   = !ro_valid || ro_ready;
      if (op_now == OP_BCAST)
         in_ready = l_free && r_free;
      else
         in_ready = to_right ? r_free : l_free;
      take   = in_valid && in_ready;
      load_l = take && ((op_now == OP_BCAST) || !to_right);
      load_r = take && ((op_now == OP_BCAST) || to_right);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         op_q     <= OP_BCAST;
         coll_q   <= 1'b0;
         lo_valid <= 1'b0;
         lo_data  <= '0;
         lo_dist  <= 1'b0;
         lo_coll  <= 1'b0;
         ro_valid <= 1'b0;
         ro_data  <= '0;
         ro_dist  <= 1'b0;
         ro_coll  <= 1'b0;
      end else begin
         if (lo_ready) lo_valid <= 1'b0;
         if (ro_ready) ro_valid <= 1'b0;
         if (load_l) begin
            lo_valid <= 1'b1;
            lo_data  <= in_data;
            lo_dist  <= (op_now == OP_SCATTER);
            lo_coll  <= coll_now;
         end
         if (load_r) begin
            ro_valid <= 1'b1;
            ro_data  <= in_data;
            ro_dist  <= (op_now == OP_SCATTER);
            ro_coll  <= coll_now;
         end
         if (take) begin
            if (cnt_q == '0) begin
               op_q   <= op_now;
               coll_q <= coll_now;
            end
            if (op_now == OP_SCATTER)
               cnt_q <= (cnt_q == CW'(LEAVES - 1)) ? '0 : cnt_q + 1'b1;
         end
      end
   end

   assert_left_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lo_valid && !lo_ready |=> lo_valid && $stable(lo_data));
   assert_right_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ro_valid && !ro_ready |=> ro_valid && $stable(ro_data));
   assert_bcast_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take && (op_now == OP_BCAST) |=> lo_valid && ro_valid);
endmodule

// File: rtl/ct_mac_leaf.sv
`timescale 1ns/1ps
module ct_mac_leaf #(
   parameter int W  = 8,
   localparam int PW = 2 * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [W-1:0]  in_data,
   input  logic          in_coll,
   input  logic [W-1:0]  weight,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [PW-1:0] out_data,
   output logic          out_coll
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_coll  <= 1'b0;
      end else if (in_valid && in_ready) begin
         out_valid <= 1'b1;
         out_data  <= PW'(in_data) * PW'(weight);
         out_coll  <= in_coll;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assert_leaf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/ct_coll_node.sv
`timescale 1ns/1ps
module ct_coll_node
   import ct_pkg::*;
#(
   parameter int IW     = 16,
   parameter int LEAVES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          l_valid,
   output logic          l_ready,
   input  logic [IW-1:0] l_data,
   input  logic          l_coll,
   input  logic          r_valid,
   output logic          r_ready,
   input  logic [IW-1:0] r_data,
   input  logic          r_coll,
   output logic          o_valid,
   input  logic          o_ready,
   output logic [IW:0]   o_data,
   output logic          o_coll
);
   localparam int HALF = LEAVES / 2;
   localparam int CW   = $clog2(LEAVES);

   logic [CW-1:0] cnt_q;
   coll_op_e      op_q, op_now;
   logic          from_right, free, fire;
   logic [IW:0]   nxt;

   always_comb begin
      op_now     = (cnt_q == '0) ? coll_op_e'({1'b1, l_coll}) : op_q;
      from_right = cnt_q >= CW'(HALF);
      free       = !o_valid || o_ready;
      if (op_now == OP_REDUCE) begin
         l_ready = free && r_valid;
         r_ready = free && l_valid;
         fire    = free && l_valid && r_valid;
         nxt     = {1'b0, l_data} + {1'b0, r_data};
      end else begin
         l_ready = free && !from_right;
         r_ready = free && from_right;
         fire    = free && (from_right ? r_valid : l_valid);
         nxt     = from_right ? {1'b0, r_data} : {1'b0, l_data};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         op_q    <= OP_REDUCE;
         o_valid <= 1'b0;
         o_data  <= '0;
         o_coll  <= 1'b0;
      end else begin
         if (o_ready) o_valid <= 1'b0;
         if (fire) begin
            o_valid <= 1'b1;
            o_data  <= nxt;
            o_coll  <= (op_now == OP_GATHER);
            if (cnt_q == '0) op_q <= op_now;
            if (op_now == OP_GATHER)
               cnt_q <= (cnt_q == CW'(LEAVES - 1)) ? '0 : cnt_q + 1'b1;
         end
      end
   end

   assert_node_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && !o_ready |=> o_valid && $stable(o_data));
   // both subtree heads at a transfer start belong to the same transfer
   assert_mode_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
      l_valid && r_valid && (cnt_q == '0) |-> l_coll == r_coll);
endmodule

// File: rtl/ct_tree.sv
`timescale 1ns/1ps
module ct_tree
   import ct_pkg::*;
#(
   parameter int N = 8,
   parameter int W = 8,
   localparam int LVL = $clog2(N),
   localparam int OW  = 2 * W + LVL
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           dist_sel,
   input  logic           coll_sel,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [W-1:0]   in_data,
   input  logic [N*W-1:0] leaf_weight,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [OW-1:0]  out_data
);
   localparam int NODES = 2 * N;

   if ((N < 2) || ((N & (N - 1)) != 0)) begin : g_bad_n
      $error("ct_tree: N must be a power of two and at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("ct_tree: W must be at least 1");
   end

   // link index = heap id of the node that receives (down) / sends (up)
   logic          dv  [1:NODES-1];
   logic          dr  [1:NODES-1];
   logic [W-1:0]  dd  [1:NODES-1];
   logic          dsc [1:NODES-1];
   logic          dcl [1:NODES-1];
   logic          uv  [1:NODES-1];
   logic          ur  [1:NODES-1];
   logic [OW-1:0] ud  [1:NODES-1];
   logic          ucl [1:NODES-1];

   assign dv[1]     = in_valid;
   assign in_ready  = dr[1];
   assign dd[1]     = in_data;
   assign dsc[1]    = dist_sel;
   assign dcl[1]    = coll_sel;
   assign out_valid = uv[1];
   assign ur[1]     = out_ready;
   assign out_data  = ud[1];

   for (genvar i = 1; i < N; i++) begin : g_node
      localparam int DEPTH = $clog2(i + 1) - 1;
      localparam int SUB   = N >> DEPTH;
      localparam int HT    = LVL - DEPTH;
      localparam int IW    = 2 * W + HT - 1;
      logic [IW:0] od;

      ct_dist_node #(.W(W), .LEAVES(SUB)) u_dist (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (dv[i]),
         .in_ready (dr[i]),
         .in_data  (dd[i]),
         .in_dist  (dsc[i]),
         .in_coll  (dcl[i]),
         .lo_valid (dv[2*i]),
         .lo_ready (dr[2*i]),
         .lo_data  (dd[2*i]),
         .lo_dist  (dsc[2*i]),
         .lo_coll  (dcl[2*i]),
         .ro_valid (dv[2*i+1]),
         .ro_ready (dr[2*i+1]),
         .ro_data  (dd[2*i+1]),
         .ro_dist  (dsc[2*i+1]),
         .ro_coll  (dcl[2*i+1])
      );

      ct_coll_node #(.IW(IW), .LEAVES(SUB)) u_coll (
         .clk     (clk),
         .rst_n   (rst_n),
         .l_valid (uv[2*i]),
         .l_ready (ur[2*i]),
         .l_data  (ud[2*i][IW-1:0]),
         .l_coll  (ucl[2*i]),
         .r_valid (uv[2*i+1]),
         .r_ready (ur[2*i+1]),
         .r_data  (ud[2*i+1][IW-1:0]),
         .r_coll  (ucl[2*i+1]),
         .o_valid (uv[i]),
         .o_ready (ur[i]),
         .o_data  (od),
         .o_coll  (ucl[i])
      );
      assign ud[i] = OW'(od);
   end

   for (genvar j = 0; j < N; j++) begin : g_leaf
      logic [2*W-1:0] prod;
      ct_mac_leaf #(.W(W)) u_leaf (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (dv[N+j]),
         .in_ready  (dr[N+j]),
         .in_data   (dd[N+j]),
         .in_coll   (dcl[N+j]),
         .weight    (leaf_weight[j*W +: W]),
         .out_valid (uv[N+j]),
         .out_ready (ur[N+j]),
         .out_data  (prod),
         .out_coll  (ucl[N+j])
      );
      assign ud[N+j] = OW'(prod);
   end

   assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   assert_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid && in_ready);
endmodule

// File: tb/sim_ct_tree.sv
`timescale 1ns/1ps
module sim_ct_tree;
   localparam int N   = 8;
   localparam int W   = 8;
   localparam int LVL = 3;
   localparam int OW  = 2 * W + LVL;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           dist_sel = 1'b0;
   logic           coll_sel = 1'b0;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic [W-1:0]   in_data = '0;
   logic [N*W-1:0] leaf_weight = '0;
   logic           out_valid;
   logic           out_ready = 1'b1;
   logic [OW-1:0]  out_data;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int drv_stalls;
   int w [0:N-1];
   logic [W-1:0] dwords [0:63];
   longint expv [0:63];
   longint got  [0:63];

   ct_tree #(.N(N), .W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .dist_sel(dist_sel), .coll_sel(coll_sel),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .leaf_weight(leaf_weight), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic set_weights(input int a0, input int a1, input int a2, input int a3,
                              input int a4, input int a5, input int a6, input int a7);
      w[0] = a0; w[1] = a1; w[2] = a2; w[3] = a3;
      w[4] = a4; w[5] = a5; w[6] = a6; w[7] = a7;
      @(negedge clk);
      for (int j = 0; j < N; j++) leaf_weight[j*W +: W] = W'(w[j]);
   endtask

   task automatic drive(input int n, input logic ds, input logic cs, input int gap, input int flip);
      int stalls = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = dwords[k];
         dist_sel = (flip != 0 && k > 0) ? ~ds : ds;
         coll_sel = (flip != 0 && k > 0) ? ~cs : cs;
         #2;
         while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #2;
         end
         @(posedge clk);
         if (gap != 0) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      drv_stalls = stalls;
   endtask

   task automatic collect(input int n, input int pat);
      int got_n = 0;
      int t = 0;
      while (got_n < n) begin
         @(negedge clk);
         out_ready = (pat == 0) ? 1'b1 : ((t % 3) != 1);
         t++;
         #1;
         if (out_valid && out_ready) begin
            got[got_n] = longint'(out_data);
            got_n++;
         end
      end
   endtask

   task automatic run(input int nw, input logic ds, input logic cs, input int nexp,
                      input int pat, input int gap, input int flip, input string rq);
      int extra = 0;
      fork
         drive(nw, ds, cs, gap, flip);
         collect(nexp, pat);
      join
      @(negedge clk);
      out_ready = 1'b1;
      for (int k = 0; k < nexp; k++) check(got[k] == expv[k], rq, got[k], expv[k]);
      repeat (10) begin
         @(negedge clk);
         #1;
         if (out_valid) extra++;
      end
      check(extra == 0, "R8 no extra results", extra, 0);
   endtask

   function automatic longint wsum();
      longint s = 0;
      for (int j = 0; j < N; j++) s += w[j];
      return s;
   endfunction

   // R11: reset state
   task automatic t_reset();
      @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);
   endtask

   // R10: empty-tree latency, broadcast+reduce value (R4)
   task automatic t_latency();
      int c0;
      int lat = -1;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'd3; dist_sel = 1'b0; coll_sel = 1'b0;
      #2;
      check(in_ready == 1'b1, "R10 idle tree ready", in_ready, 1);
      c0 = cyc;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      for (int t = 0; t < 40 && lat < 0; t++) begin
         #1;
         if (out_valid) begin
            lat = cyc - (c0 + 1);
            got[0] = longint'(out_data);
         end else begin
            @(negedge clk);
         end
      end
      check(lat == 2 * LVL, "R10 latency", lat, 2 * LVL);
      check(got[0] == 3 * wsum(), "R4 broadcast+reduce", got[0], 3 * wsum());
      repeat (3) @(negedge clk);
   endtask

   // R2, R5, R1: broadcast then gather
   task automatic t_bcast_gather();
      dwords[0] = 8'd10;
      for (int k = 0; k < N; k++) expv[k] = 10 * w[k];
      run(1, 1'b0, 1'b1, N, 0, 0, 0, "R2 R5 broadcast+gather");
   endtask

   // R3, R5: scatter then gather
   task automatic t_scatter_gather();
      for (int k = 0; k < N; k++) begin
         dwords[k] = W'(k * 11 + 1);
         expv[k] = longint'(k * 11 + 1) * w[k];
      end
      run(N, 1'b1, 1'b1, N, 0, 0, 0, "R3 R5 scatter+gather");
   endtask

   // R4, R12: back-to-back broadcast+reduce
   task automatic t_bcast_reduce_stream();
      for (int k = 0; k < 6; k++) begin
         dwords[k] = W'(k + 1);
         expv[k] = longint'(k + 1) * wsum();
      end
      run(6, 1'b0, 1'b0, 6, 0, 0, 0, "R4 broadcast+reduce stream");
      check(drv_stalls == 0, "R12 one word per cycle", drv_stalls, 0);
   endtask

   // R4: scatter then reduce is a dot product
   task automatic t_scatter_reduce();
      longint s = 0;
      for (int k = 0; k < N; k++) begin
         dwords[k] = W'(20 + k);
         s += longint'(20 + k) * w[k];
      end
      expv[0] = s;
      run(N, 1'b1, 1'b0, 1, 0, 0, 0, "R4 scatter+reduce");
   endtask

   // R6: widest operands
   task automatic t_max();
      set_weights(255, 255, 255, 255, 255, 255, 255, 255);
      for (int k = 0; k < N; k++) dwords[k] = 8'hFF;
      expv[0] = 8 * 65025;
      run(N, 1'b1, 1'b0, 1, 0, 0, 0, "R6 max scatter+reduce");
      dwords[0] = 8'hFF;
      for (int k = 0; k < N; k++) expv[k] = 65025;
      run(1, 1'b0, 1'b1, N, 0, 0, 0, "R6 max broadcast+gather");
   endtask

   // R7: selects flipped after the first word are ignored
   task automatic t_mode_hold();
      for (int k = 0; k < N; k++) begin
         dwords[k] = W'(3 * k + 2);
         expv[k] = longint'(3 * k + 2) * w[k];
      end
      run(N, 1'b1, 1'b1, N, 0, 0, 1, "R7 mode held for transfer");
   endtask

   // R8, R9: backpressure and input gaps
   task automatic t_stall();
      dwords[0] = 8'd77;
      for (int k = 0; k < N; k++) expv[k] = 77 * w[k];
      run(1, 1'b0, 1'b1, N, 1, 1, 0, "R8 R9 stalled broadcast+gather");
      for (int k = 0; k < 5; k++) begin
         dwords[k] = W'(9 * k + 4);
         expv[k] = longint'(9 * k + 4) * wsum();
      end
      run(5, 1'b0, 1'b0, 5, 1, 0, 0, "R8 R9 stalled broadcast+reduce");
      for (int k = 0; k < N; k++) begin
         dwords[k] = W'(200 - k);
         expv[k] = longint'(200 - k) * w[k];
      end
      run(N, 1'b1, 1'b1, N, 1, 1, 0, "R8 stalled scatter+gather");
   endtask

   initial begin
      wait (cyc >= 100000);
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      set_weights(3, 5, 7, 2, 9, 1, 4, 6);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latency();
      t_bcast_gather();
      t_scatter_gather();
      t_bcast_reduce_stream();
      t_scatter_reduce();
      t_mode_hold();
      t_stall();
      t_max();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule